// File: doc/BRIEF.md
# Translating TLB with Built-in Page-Table Walker

This block turns a virtual address into a physical address. It keeps a small fully associative cache of recent translations. Each access arrives with an access kind (load, store, fetch, or read-modify-write). On a cached translation the block checks the access against the stored permissions. It then forms the physical address from the cached frame number and the untouched page offset. If the permission check fails it reports a protection fault.

When no entry matches, the block walks a one-level page table itself. It computes the entry address from a table base register and the page number, then issues a single read on a plain request/response memory port. It inspects the returned entry: a clear valid flag gives a segmentation fault, and missing permissions give a protection fault. A usable entry is installed in a free slot, or else in a round-robin victim, and the lookup is then run again so that it hits.

Writing the base register switches address spaces and so empties the cache. If that write lands during a walk, the fetched entry is thrown away and the lookup starts over against the new table. Every request ends with a one-cycle completion pulse that carries the fault code, the physical address, and whether the request was served without a walk.

Top module: `xlat_walk_tlb`

## Requirements
- R1: After reset `req_ready` is 1 and `done` and `mem_req_valid` are 0. No entry is valid, so the first access of any page walks the table.
- R2: The page number is the upper `VA_W-OFF_W` bits of `req_va` and the offset is the lower `OFF_W` bits. A hit with sufficient permission completes one cycle after acceptance with `done_fault`=0, `done_hit`=1 and `done_pa` = {frame, offset}, and makes no memory read.
- R3: A hit whose permissions do not allow the access completes one cycle after acceptance with `done_fault`=1 (protection) and `done_pa`=0, and makes no memory read.
- R4: A miss makes exactly one read, at address `base + page * PTE_BYTES` (with the default configuration, `base + page`). Entry layout: bit 7 valid, bit 6 readable, bit 5 writable, bit 4 executable, bits 3:0 frame number.
- R5: A fetched entry with its valid bit clear completes four cycles after acceptance with `done_fault`=2 (segmentation) and is not installed: a repeat access walks again.
- R6: A valid fetched entry without the needed permission completes four cycles after acceptance with `done_fault`=1 and is not installed.
- R7: A usable fetched entry is installed and the lookup is retried. The request completes six cycles after acceptance with `done_fault`=0, `done_hit`=0 and the translated address, and the next access to that page hits.
- R8: A write on `base_we` loads the base register and invalidates every entry, so previously cached pages miss afterwards.
- R9: A base write while a walk is outstanding discards the fetched entry. The lookup restarts and walks the new table: two reads in total, the second at the new base, and completion ten cycles after acceptance on success.
- R10: An install takes the lowest-numbered invalid slot. When all slots are valid it takes the slot at a round-robin pointer, which starts at 0 and advances by one (wrapping) after each such replacement.
- R11: Ten 4-byte loads from virtual address 100 upward, starting from an empty cache, give the pattern miss, hit, hit, miss, hit, hit, hit, miss, hit, hit. Repeating them gives ten hits.
- R12: Access codes on `req_acc`: 0 load needs readable, 1 store needs writable, 2 fetch needs executable, 3 read-modify-write needs both readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_va | input | VA_W | Virtual address |
| req_acc | input | 2 | Access kind code (see R12) |
| base_we | input | 1 | Load page-table base and empty the cache |
| base_wdata | input | MEM_AW | New page-table base |
| mem_req_valid | output | 1 | One-cycle read request for a table entry |
| mem_req_addr | output | MEM_AW | Table entry address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | PFN_W+4 | Fetched table entry |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Request served without a walk |
| done_fault | output | 2 | 0 none, 1 protection, 2 segmentation |
| done_pa | output | PFN_W+OFF_W | Physical address, 0 on a fault |

## Verification
A stale or missing valid bit shows up on the next access to the affected page. `done_hit` takes the wrong value and the completion pulse arrives on the wrong cycle, one versus six cycles after acceptance, while the read counter on the memory port disagrees. A round-robin pointer that is off by one evicts the wrong page. This is seen as an unexpected miss on the first later reference to the page that should have survived. The bench models the cache contents, the victim pointer and the table memory behaviourally. On every cycle of every request it checks whether `done` should be high, and at completion it compares the fault code, the address, the hit flag, the read count and the last read address.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RMW   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PROT = 2'd1,
        FLT_SEG  = 2'd2,
        FLT_RSVD = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK_REQ,
        ST_WALK_WAIT,
        ST_CHECK,
        ST_INSERT,
        ST_DONE
    } st_e;

    // perm: bit 2 readable, bit 1 writable, bit 0 executable
    function automatic logic perm_ok(input logic [2:0] perm, input acc_e acc);
        logic ok;
        case (acc)
            ACC_LOAD:  ok = perm[2];
            ACC_STORE: ok = perm[1];
            ACC_FETCH: ok = perm[0];
            default:   ok = perm[2] & perm[1];
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_tag_array.sv
module xlat_tag_array #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 4,
    parameter int PFN_W   = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic [2:0]         wr_perm,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               hit,
    output logic [PFN_W-1:0]   hit_pfn,
    output logic [2:0]         hit_perm,
    output logic [ENTRIES-1:0] valid_vec
);

    typedef struct packed {
        logic             v;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic [2:0]       perm;
    } ent_t;

    ent_t [ENTRIES-1:0] ent_d, ent_q;
    logic [ENTRIES-1:0] hit_vec;

    always_comb begin
        ent_d = ent_q;
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) ent_d[i].v = 1'b0;
        end else if (wr_en) begin
            ent_d[wr_idx].v    = 1'b1;
            ent_d[wr_idx].vpn  = wr_vpn;
            ent_d[wr_idx].pfn  = wr_pfn;
            ent_d[wr_idx].perm = wr_perm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign hit_vec[g]   = ent_q[g].v && (ent_q[g].vpn == lk_vpn);
        assign valid_vec[g] = ent_q[g].v;
    end

    always_comb begin
        hit_pfn  = '0;
        hit_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_pfn  = hit_pfn  | ent_q[i].pfn;
                hit_perm = hit_perm | ent_q[i].perm;
            end
        end
    end

    assign hit = |hit_vec;

    // R10: installs only on misses, so one page never occupies two slots
    assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R8: an address-space switch leaves no valid slot behind
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               advance,
    output logic [IDX_W-1:0]   idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_d, rr_q;
    logic             full;

    assign full = &valid_vec;

    always_comb begin
        idx = rr_q;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        rr_d = rr_q;
        if (advance && full) rr_d = (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rr_q <= '0;
        else        rr_q <= rr_d;
    end

    // R10: a free slot is always chosen ahead of evicting a live one
    assert_free_slot_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && advance) |-> !valid_vec[idx]);

endmodule

// File: rtl/xlat_walk_tlb.sv
module xlat_walk_tlb
    import xlat_pkg::*;
#(
    parameter int               VA_W      = 8,
    parameter int               OFF_W     = 4,
    parameter int               PFN_W     = 4,
    parameter int               MEM_AW    = 8,
    parameter int               PTE_BYTES = 1,
    parameter int               ENTRIES   = 4,
    parameter logic [MEM_AW-1:0] BASE_RST = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_va,
    input  logic [1:0]             req_acc,
    input  logic                   base_we,
    input  logic [MEM_AW-1:0]      base_wdata,
    output logic                   mem_req_valid,
    output logic [MEM_AW-1:0]      mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [PFN_W+3:0]       mem_rsp_data,
    output logic                   done,
    output logic                   done_hit,
    output logic [1:0]             done_fault,
    output logic [PFN_W+OFF_W-1:0] done_pa
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PTE_W = PFN_W + 4;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [MEM_AW-1:0] PTE_SZ = MEM_AW'(PTE_BYTES);

    typedef struct packed {
        st_e               st;
        logic [VA_W-1:0]   va;
        acc_e              acc;
        logic              walked;
        logic              discard;
        logic [PTE_W-1:0]  pte;
        logic [1:0]        flt;
        logic [PA_W-1:0]   pa;
        logic [MEM_AW-1:0] base;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             hit;
    logic [PFN_W-1:0] hit_pfn;
    logic [2:0]       hit_perm;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0] victim;
    logic             ins_en;
    logic [VPN_W-1:0] cur_vpn;
    logic [OFF_W-1:0] cur_off;
    logic             pte_valid;
    logic [2:0]       pte_perm;

    assign cur_vpn   = ctl_q.va[VA_W-1:OFF_W];
    assign cur_off   = ctl_q.va[OFF_W-1:0];
    assign pte_valid = ctl_q.pte[PTE_W-1];
    assign pte_perm  = ctl_q.pte[PFN_W+2:PFN_W];
    assign ins_en    = (ctl_q.st == ST_INSERT) && !base_we;

    xlat_tag_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (base_we),
        .wr_en     (ins_en),
        .wr_idx    (victim),
        .wr_vpn    (cur_vpn),
        .wr_pfn    (ctl_q.pte[PFN_W-1:0]),
        .wr_perm   (pte_perm),
        .lk_vpn    (cur_vpn),
        .hit       (hit),
        .hit_pfn   (hit_pfn),
        .hit_perm  (hit_perm),
        .valid_vec (valid_vec)
    );

    xlat_victim_pick #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .advance   (ins_en),
        .idx       (victim)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (base_we) ctl_d.base = base_wdata;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.va      = req_va;
                    ctl_d.acc     = acc_e'(req_acc);
                    ctl_d.walked  = 1'b0;
                    ctl_d.discard = 1'b0;
                    ctl_d.st      = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (hit) begin
                    ctl_d.st = ST_DONE;
                    if (perm_ok(hit_perm, ctl_q.acc)) begin
                        ctl_d.flt = FLT_NONE;
                        ctl_d.pa  = {hit_pfn, cur_off};
                    end else begin
                        ctl_d.flt = FLT_PROT;
                        ctl_d.pa  = '0;
                    end
                end else begin
                    ctl_d.walked = 1'b1;
                    ctl_d.st     = ST_WALK_REQ;
                end
            end
            ST_WALK_REQ: begin
                if (base_we) ctl_d.discard = 1'b1;
                ctl_d.st = ST_WALK_WAIT;
            end
            ST_WALK_WAIT: begin
                if (base_we) ctl_d.discard = 1'b1;
                if (mem_rsp_valid) begin
                    ctl_d.pte = mem_rsp_data;
                    ctl_d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (ctl_q.discard || base_we) begin
                    ctl_d.discard = 1'b0;
                    ctl_d.st      = ST_LOOKUP;
                end else if (!pte_valid) begin
                    ctl_d.flt = FLT_SEG;
                    ctl_d.pa  = '0;
                    ctl_d.st  = ST_DONE;
                end else if (!perm_ok(pte_perm, ctl_q.acc)) begin
                    ctl_d.flt = FLT_PROT;
                    ctl_d.pa  = '0;
                    ctl_d.st  = ST_DONE;
                end else begin
                    ctl_d.st = ST_INSERT;
                end
            end
            ST_INSERT: begin
                ctl_d.st = ST_LOOKUP;
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.base <= BASE_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready     = (ctl_q.st == ST_IDLE);
    assign mem_req_valid = (ctl_q.st == ST_WALK_REQ);
    assign mem_req_addr  = ctl_q.base + (MEM_AW'(cur_vpn) * PTE_SZ);
    assign done          = (ctl_q.st == ST_DONE);
    assign done_hit      = !ctl_q.walked;
    assign done_fault    = ctl_q.flt;
    assign done_pa       = ctl_q.pa;

    // R4: each walk issues a single one-cycle read
    assert_one_read_per_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R7: completion is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a faulting request never exposes an address
    assert_fault_zero_pa_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (done_fault != 2'd0)) |-> (done_pa == '0));

    // R1: no new request is taken while a walk is outstanding
    assert_busy_during_walk_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

endmodule

// File: tb/xlat_walk_tlb_bench.sv
module xlat_walk_tlb_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ENT        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_va = '0;
    logic [1:0] req_acc = '0;
    logic       base_we = 1'b0;
    logic [7:0] base_wdata = '0;
    logic       mem_req_valid;
    logic [7:0] mem_req_addr;
    logic       mem_rsp_valid = 1'b0;
    logic [7:0] mem_rsp_data = '0;
    logic       done;
    logic       done_hit;
    logic [1:0] done_fault;
    logic [7:0] done_pa;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int rd_cnt = 0;
    logic [7:0] rd_last = '0;

    logic [7:0] pmem [256];

    // behavioural model of cache state
    bit         m_v    [ENT];
    logic [3:0] m_vpn  [ENT];
    logic [3:0] m_pfn  [ENT];
    logic [2:0] m_perm [ENT];
    int         m_rr;
    logic [7:0] m_base;

    xlat_walk_tlb u_xlat_walk_tlb (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .req_acc       (req_acc),
        .base_we       (base_we),
        .base_wdata    (base_wdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .done_hit      (done_hit),
        .done_fault    (done_fault),
        .done_pa       (done_pa)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // table memory: answers one cycle after a request
    always @(posedge clk) begin
        mem_rsp_valid <= mem_req_valid;
        mem_rsp_data  <= pmem[mem_req_addr];
        if (mem_req_valid) begin
            rd_cnt  = rd_cnt + 1;
            rd_last = mem_req_addr;
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit allowed(input logic [2:0] perm, input logic [1:0] acc);
        case (acc)
            2'd0: return perm[2];
            2'd1: return perm[1];
            2'd2: return perm[0];
            default: return perm[2] && perm[1];
        endcase
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
    endfunction

    task automatic set_base(input logic [7:0] nb);
        @(negedge clk);
        base_we = 1'b1; base_wdata = nb;
        @(negedge clk);
        base_we = 1'b0;
        model_clear();
        m_base = nb;
    endtask

    task automatic xact(input logic [7:0] va, input logic [1:0] acc,
                        input bit mid_flush, input logic [7:0] nb,
                        input string req, output bit got_hit);
        int hit_at, lat, reads, r0, seen_lat;
        logic [1:0] e_flt;
        logic [7:0] e_pa, e_addr, p, a;
        bit e_hit, late_bad;
        logic [1:0] g_flt;
        logic [7:0] g_pa;
        bit g_hit;
        // expectation
        hit_at = -1;
        for (int i = 0; i < ENT; i++)
            if (m_v[i] && m_vpn[i] == va[7:4]) hit_at = i;
        reads = 0; e_addr = '0;
        if (hit_at >= 0) begin
            lat = 1; e_hit = 1'b1;
            if (allowed(m_perm[hit_at], acc)) begin
                e_flt = 2'd0; e_pa = {m_pfn[hit_at], va[3:0]};
            end else begin
                e_flt = 2'd1; e_pa = '0;
            end
        end else begin
            lat = 0; e_hit = 1'b0;
            if (mid_flush) begin
                model_clear(); m_base = nb; lat = 4; reads = 1;
            end
            a = m_base + {4'd0, va[7:4]};
            p = pmem[a];
            reads = reads + 1; e_addr = a;
            if (!p[7]) begin
                e_flt = 2'd2; e_pa = '0; lat = lat + 4;
            end else if (!allowed(p[6:4], acc)) begin
                e_flt = 2'd1; e_pa = '0; lat = lat + 4;
            end else begin
                int slot;
                slot = -1;
                for (int i = ENT - 1; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) begin
                    slot = m_rr; m_rr = (m_rr + 1) % ENT;
                end
                m_v[slot] = 1'b1; m_vpn[slot] = va[7:4];
                m_pfn[slot] = p[3:0]; m_perm[slot] = p[6:4];
                e_flt = 2'd0; e_pa = {p[3:0], va[3:0]}; lat = lat + 6;
            end
        end
        // drive and observe every cycle
        chk(req_ready === 1'b1, req, "ready before request", int'(req_ready), 1);
        r0 = rd_cnt;
        req_va = va; req_acc = acc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        late_bad = 1'b0; seen_lat = -1;
        g_flt = '0; g_pa = '0; g_hit = 1'b0;
        for (int k = 0; k <= lat + 1; k++) begin
            if (k > 0) @(negedge clk);
            if (mid_flush && k == 2) begin base_we = 1'b1; base_wdata = nb; end
            if (mid_flush && k == 3) base_we = 1'b0;
            if (done !== (k == lat)) late_bad = 1'b1;
            if (done === 1'b1) begin
                seen_lat = k; g_flt = done_fault; g_pa = done_pa; g_hit = done_hit;
            end
        end
        chk(!late_bad, req, "done timing", seen_lat, lat);
        chk(g_flt == e_flt, req, "fault code", int'(g_flt), int'(e_flt));
        chk(g_pa == e_pa, req, "physical address", int'(g_pa), int'(e_pa));
        chk(g_hit == e_hit, req, "hit flag", int'(g_hit), int'(e_hit));
        chk(rd_cnt - r0 == reads, req, "table reads", rd_cnt - r0, reads);
        if (reads > 0)
            chk(rd_last == e_addr, req, "last read address", int'(rd_last), int'(e_addr));
        got_hit = g_hit;
    endtask

    initial begin
        bit h;
        bit trace[10];
        bit pat[10];
        bit rpat[11];
        logic [3:0] rseq[11];
        for (int i = 0; i < 256; i++) pmem[i] = 8'h00;
        // table at 0x40: full rights, frame = page ^ 0xA, with special pages
        for (int v = 0; v < 16; v++) pmem[8'h40 + v] = {1'b1, 3'b111, 4'(v) ^ 4'hA};
        pmem[8'h4C] = 8'h00;                 // page 12 invalid
        pmem[8'h4D] = {1'b1, 3'b100, 4'h3};  // page 13 read only
        pmem[8'h4E] = {1'b1, 3'b001, 4'h5};  // page 14 execute only
        pmem[8'h4F] = {1'b1, 3'b110, 4'h6};  // page 15 read/write
        // table at 0x80: frame = 15 - page
        for (int v = 0; v < 16; v++) pmem[8'h80 + v] = {1'b1, 3'b111, 4'(15 - v)};
        model_clear(); m_rr = 0; m_base = 8'h00;

        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1, "R1", "reset ready", int'(req_ready), 1);
        chk(done === 1'b0, "R1", "reset done", int'(done), 0);
        chk(mem_req_valid === 1'b0, "R1", "reset mem request", int'(mem_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        set_base(8'h40);

        // R11: array walk from address 100, 4-byte stride
        pat = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
        for (int i = 0; i < 10; i++) begin
            xact(8'(100 + 4 * i), 2'd0, 1'b0, 8'h00, "R11", h);
            trace[i] = h;
        end
        for (int i = 0; i < 10; i++)
            chk(trace[i] == pat[i], "R11", "cold pass hit pattern", int'(trace[i]), int'(pat[i]));
        for (int i = 0; i < 10; i++) begin
            xact(8'(100 + 4 * i), 2'd0, 1'b0, 8'h00, "R11", h);
            chk(h == 1'b1, "R11", "warm pass hit", int'(h), 1);
        end

        // R2: offset carried through on a hit
        xact(8'h65, 2'd0, 1'b0, 8'h00, "R2", h);
        xact(8'h7F, 2'd1, 1'b0, 8'h00, "R2", h);

        // R4 / R7: a new page walks once, then hits
        xact(8'h93, 2'd0, 1'b0, 8'h00, "R4", h);
        xact(8'hA7, 2'd2, 1'b0, 8'h00, "R7", h);
        xact(8'hA1, 2'd0, 1'b0, 8'h00, "R7", h);
        chk(h == 1'b1, "R7", "retry installed entry", int'(h), 1);

        // R3: page 13 read-only, install via load then store hits and faults
        xact(8'hD0, 2'd0, 1'b0, 8'h00, "R3", h);
        xact(8'hD4, 2'd1, 1'b0, 8'h00, "R3", h);

        // R5: invalid entry faults and is never cached
        xact(8'hC0, 2'd0, 1'b0, 8'h00, "R5", h);
        xact(8'hC8, 2'd0, 1'b0, 8'h00, "R5", h);
        chk(h == 1'b0, "R5", "invalid entry not cached", int'(h), 0);

        // R6: walk finds entry lacking rights
        xact(8'hE0, 2'd0, 1'b0, 8'h00, "R6", h);
        xact(8'hE0, 2'd1, 1'b0, 8'h00, "R6", h);
        chk(h == 1'b0, "R6", "refused entry not cached", int'(h), 0);

        // R12: read-modify-write and fetch encodings
        xact(8'hF2, 2'd3, 1'b0, 8'h00, "R12", h);
        xact(8'hF2, 2'd2, 1'b0, 8'h00, "R12", h);
        xact(8'hD2, 2'd3, 1'b0, 8'h00, "R12", h);
        xact(8'hE6, 2'd2, 1'b0, 8'h00, "R12", h);

        // R8: base write empties the cache
        set_base(8'h40);
        xact(8'h64, 2'd0, 1'b0, 8'h00, "R8", h);
        chk(h == 1'b0, "R8", "page misses after flush", int'(h), 0);

        // R10: replacement order
        set_base(8'h40);
        rseq = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd0, 4'd2, 4'd3, 4'd4, 4'd1, 4'd2};
        rpat = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
        for (int i = 0; i < 11; i++) begin
            xact({rseq[i], 4'h8}, 2'd0, 1'b0, 8'h00, "R10", h);
            chk(h == rpat[i], "R10", "victim choice pattern", int'(h), int'(rpat[i]));
        end

        // R9: base switch during a walk
        xact(8'h5C, 2'd0, 1'b1, 8'h80, "R9", h);
        xact(8'h51, 2'd0, 1'b0, 8'h00, "R9", h);
        chk(h == 1'b1, "R9", "second walk installed", int'(h), 1);
        xact(8'h6C, 2'd0, 1'b0, 8'h00, "R9", h);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule